// File: doc/BRIEF.md
# Walking-One Switch Matrix Scanner

This block reads up to eight switches whose contacts sit on the parallel outputs of an external serial-in shift register. All switch poles join one common sense line, `pole_n`. When a switch is closed, it pulls that line low. The block drives the register's data and clock lines and pushes a single one through the outputs, one position per clock pulse. After each pulse it samples the pole. The result is a map of the closed switches, with step 0 as the least significant bit.

A group of bits chosen by `rot_mask` belongs to a rotary selector. The block turns that group into a position index: the lowest set bit inside the mask wins. When no masked bit is set, the search still ends and gives the highest position. The new map and the new index appear together, with a one-cycle `scan_valid` pulse.

A pass runs once after a `start` pulse. Passes also repeat back to back for as long as `free_run` is high. The high and low times of the shift clock are parameters counted in system clocks. An optional settling wait (`SETTLE_CYC`, zero by default) makes the low phase of every step longer.

Top module: `swscan_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sr_clk`, `sr_data` and `scan_valid` are 0, `sw_map` is 0 and `rot_idx` is 0. A reset in the middle of a pass abandons that pass.
- R2: In each pass, `sr_data` is 1 during the first shift clock pulse and 0 during every later one.
- R3: Every step has three parts: one setup cycle, then `sr_clk` high for `CLK_HI` cycles, then low for `CLK_LO + SETTLE_CYC` cycles. `sr_data` is steady while `sr_clk` is high. The pole is sampled on the last low cycle. A pass takes `NUM_POS` rising shift clock edges. `scan_valid` goes high `NUM_POS*(1+CLK_HI+CLK_LO+SETTLE_CYC)` cycles after the edge that accepted the start.
- R4: Bit k of `sw_map` is 1 exactly when `pole_n` was low at the sample point of step k. Step k is the step that follows the (k+1)-th shift clock of the pass, and bit 0 is the least significant bit.
- R5: Each pass builds its map from all zeros. No bit from an earlier pass survives into a later one.
- R6: `rot_idx` is the index of the lowest set bit of `sw_map & rot_mask`. So a masked group holding 1, 2 or 4 gives 0, 1 or 2.
- R7: When `sw_map & rot_mask` is zero, `rot_idx` is `NUM_POS-1`.
- R8: `scan_valid` lasts one cycle. `sw_map` and `rot_idx` change only on the cycle where `scan_valid` is high, and they hold their values otherwise.
- R9: A `start` pulse that arrives during a pass has no effect. That pass keeps its length, and no extra pass follows it.
- R10: While `free_run` is high, a new pass begins on the cycle after each `scan_valid`. The period between pulses is then `NUM_POS*(1+CLK_HI+CLK_LO+SETTLE_CYC)+1` cycles. When `free_run` is low and `start` is 0, no pass begins.
- R11: A nonzero `SETTLE_CYC` adds that many cycles to the low phase of every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins one pass when the block is idle |
| free_run | input | 1 | While high, passes repeat back to back |
| rot_mask | input | NUM_POS | Selects the bits that belong to the rotary selector |
| pole_n | input | 1 | Common switch pole; low means closed |
| sr_clk | output | 1 | Shift clock to the external register |
| sr_data | output | 1 | Serial data to the external register |
| sw_map | output | NUM_POS | Closed-switch map from the last pass |
| rot_idx | output | $clog2(NUM_POS) | Rotary position from the last pass |
| scan_valid | output | 1 | One-cycle pulse when the map and index update |

## Verification
The rotary check needs `rot_mask` to stay unchanged from the start of a pass until its `scan_valid` pulse. It also expects `pole_n` to change only soon after a rising shift clock edge, well before the sample point. The bench keeps to both assumptions. It models the external register with a shift that happens on every rising edge of `sr_clk`, so the pole derived from that model only moves at those instants. It sets the switch pattern and the mask while the block is idle, before raising `start`.

// File: rtl/swscan_pkg.sv
package swscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } scan_state_e;

  // Index of the lowest set bit of v among the first n bits; n-1 when none is set.
  function automatic int unsigned lowest_set(input logic [31:0] v, input int unsigned n);
    int unsigned r;
    r = n - 1;
    for (int i = 31; i >= 0; i--) begin
      if ((i < int'(n)) && v[i]) r = unsigned'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/swscan_phase_timer.sv
module swscan_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] len,
  output logic          expire
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= len - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == '0);

endmodule

// File: rtl/swscan_seq.sv
module swscan_seq
  import swscan_pkg::*;
#(
  parameter int NUM_POS = 8,
  parameter int CLK_HI  = 2,
  parameter int LOW_CYC = 2,
  localparam int SW     = $clog2(NUM_POS),
  localparam int PH_MAX = (CLK_HI > LOW_CYC) ? CLK_HI : LOW_CYC,
  localparam int CW     = $clog2(PH_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          free_run,
  output logic          sr_clk,
  output logic          sr_data,
  output logic          sample_stb,
  output logic          pass_last,
  output logic          first_step,
  output logic [SW-1:0] step_idx
);

  scan_state_e   state, nxt;
  logic [SW-1:0] step, nxt_step;
  logic          restart, expire;
  logic [CW-1:0] rlen;

  swscan_phase_timer #(.CW(CW)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .len    (rlen),
    .expire (expire)
  );

  always_comb begin
    nxt      = state;
    nxt_step = step;
    restart  = 1'b0;
    rlen     = CW'(CLK_HI);
    case (state)
      ST_IDLE: begin
        if (start || free_run) begin
          nxt      = ST_SETUP;
          nxt_step = '0;
        end
      end
      ST_SETUP: begin
        nxt     = ST_HIGH;
        restart = 1'b1;
        rlen    = CW'(CLK_HI);
      end
      ST_HIGH: begin
        if (expire) begin
          nxt     = ST_LOW;
          restart = 1'b1;
          rlen    = CW'(LOW_CYC);
        end
      end
      ST_LOW: begin
        if (expire) begin
          if (step == SW'(NUM_POS - 1)) begin
            nxt      = ST_IDLE;
            nxt_step = '0;
          end else begin
            nxt      = ST_SETUP;
            nxt_step = step + 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      step    <= '0;
      sr_clk  <= 1'b0;
      sr_data <= 1'b0;
    end else begin
      state   <= nxt;
      step    <= nxt_step;
      sr_clk  <= (nxt == ST_HIGH);
      sr_data <= ((nxt == ST_SETUP) || (nxt == ST_HIGH)) && (nxt_step == '0);
    end
  end

  assign sample_stb = (state == ST_LOW) && expire;
  assign pass_last  = sample_stb && (step == SW'(NUM_POS - 1));
  assign first_step = (step == '0);
  assign step_idx   = step;

endmodule

// File: rtl/swscan_collect.sv
module swscan_collect #(
  parameter int NUM_POS = 8,
  localparam int SW     = $clog2(NUM_POS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_stb,
  input  logic               pass_last,
  input  logic [SW-1:0]      step_idx,
  input  logic               pole_n,
  input  logic [NUM_POS-1:0] rot_mask,
  output logic [NUM_POS-1:0] sw_map,
  output logic [SW-1:0]      rot_idx,
  output logic               scan_valid
);

  logic [NUM_POS-1:0] accum, accum_nxt;

  // Each bit takes the sample on its own step and is cleared on step 0.
  for (genvar k = 0; k < NUM_POS; k++) begin : g_bit
    assign accum_nxt[k] = (sample_stb && (step_idx == SW'(k))) ? ~pole_n :
                          (sample_stb && (step_idx == '0))     ? 1'b0    :
                                                                 accum[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accum      <= '0;
      sw_map     <= '0;
      rot_idx    <= '0;
      scan_valid <= 1'b0;
    end else begin
      accum      <= accum_nxt;
      scan_valid <= pass_last;
      if (pass_last) begin
        sw_map  <= accum_nxt;
        rot_idx <= SW'(swscan_pkg::lowest_set(32'(accum_nxt & rot_mask), NUM_POS));
      end
    end
  end

endmodule

// File: rtl/swscan_top.sv
module swscan_top #(
  parameter int NUM_POS    = 8,
  parameter int CLK_HI     = 2,
  parameter int CLK_LO     = 2,
  parameter int SETTLE_CYC = 0,
  localparam int SW        = $clog2(NUM_POS),
  localparam int LOW_CYC   = CLK_LO + SETTLE_CYC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               free_run,
  input  logic [NUM_POS-1:0] rot_mask,
  input  logic               pole_n,
  output logic               sr_clk,
  output logic               sr_data,
  output logic [NUM_POS-1:0] sw_map,
  output logic [SW-1:0]      rot_idx,
  output logic               scan_valid
);

  // Named internal events, visible to the bound checker.
  logic          sample_stb;
  logic          pass_last;
  logic          first_step;
  logic [SW-1:0] step_idx;

  swscan_seq #(
    .NUM_POS(NUM_POS),
    .CLK_HI (CLK_HI),
    .LOW_CYC(LOW_CYC)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .free_run  (free_run),
    .sr_clk    (sr_clk),
    .sr_data   (sr_data),
    .sample_stb(sample_stb),
    .pass_last (pass_last),
    .first_step(first_step),
    .step_idx  (step_idx)
  );

  swscan_collect #(.NUM_POS(NUM_POS)) i_collect (
    .clk       (clk),
    .rst       (rst),
    .sample_stb(sample_stb),
    .pass_last (pass_last),
    .step_idx  (step_idx),
    .pole_n    (pole_n),
    .rot_mask  (rot_mask),
    .sw_map    (sw_map),
    .rot_idx   (rot_idx),
    .scan_valid(scan_valid)
  );

endmodule

// File: rtl/swscan_chk.sv
module swscan_chk #(
  parameter int NUM_POS = 8,
  localparam int SW     = $clog2(NUM_POS)
) (
  input logic               clk,
  input logic               rst,
  input logic               sr_clk,
  input logic               sr_data,
  input logic               first_step,
  input logic               sample_stb,
  input logic               scan_valid,
  input logic [NUM_POS-1:0] rot_mask,
  input logic [NUM_POS-1:0] sw_map,
  input logic [SW-1:0]      rot_idx
);

  logic [NUM_POS-1:0] below_idx;
  assign below_idx = NUM_POS'((1 << rot_idx) - 1);

  assert_data_first_R2: assert property (@(posedge clk) disable iff (rst)
    sr_clk |-> (sr_data == first_step));

  assert_data_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (sr_clk && $past(sr_clk)) |-> $stable(sr_data));

  assert_sample_clk_low_R3: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> !sr_clk);

  assert_rot_lowest_R6: assert property (@(posedge clk) disable iff (rst)
    scan_valid |-> ((sw_map & rot_mask & below_idx) == '0));

  assert_rot_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (scan_valid && (rot_idx != SW'(NUM_POS - 1))) |-> ((sw_map & rot_mask) != '0));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    scan_valid |=> !scan_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !scan_valid |-> ($stable(sw_map) && $stable(rot_idx)));

endmodule

bind swscan_top swscan_chk #(.NUM_POS(NUM_POS)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .sr_clk    (sr_clk),
  .sr_data   (sr_data),
  .first_step(first_step),
  .sample_stb(sample_stb),
  .scan_valid(scan_valid),
  .rot_mask  (rot_mask),
  .sw_map    (sw_map),
  .rot_idx   (rot_idx)
);

// File: tb/test_swscan_top.sv
`timescale 1ns/1ps
module test_swscan_top;

  localparam int N    = 8;
  localparam int HI   = 2;
  localparam int LO   = 2;
  localparam int SET2 = 3;
  localparam int PASS = N * (1 + HI + LO);
  localparam int PASS2 = N * (1 + HI + LO + SET2);

  // {closed switches, rotary mask}
  localparam logic [15:0] VEC [10] = '{
    {8'h00, 8'h07}, {8'h01, 8'h07}, {8'h02, 8'h07}, {8'h04, 8'h07},
    {8'hA5, 8'hF0}, {8'h02, 8'h03}, {8'hFF, 8'h80}, {8'h5A, 8'h00},
    {8'h80, 8'h7F}, {8'h3C, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, free_run = 1'b0, start2 = 1'b0;
  logic [7:0] mask = 8'h00, closed = 8'h00;
  logic [7:0] srq = 8'h00;
  wire pole_n = ~|(srq & closed);

  logic sr_clk, sr_data, scan_valid;
  logic [7:0] sw_map;
  logic [2:0] rot_idx;
  logic sr_clk2, sr_data2, valid2;
  logic [7:0] map2;
  logic [2:0] rot2;

  int cmp = 0, mism = 0;
  int rises = 0, ones = 0, hi_run = 0;
  bit late_one = 0, hi_bad = 0;

  always #2 clk = ~clk;

  swscan_top #(.NUM_POS(N), .CLK_HI(HI), .CLK_LO(LO)) i_swscan_top (
    .clk(clk), .rst(rst), .start(start), .free_run(free_run),
    .rot_mask(mask), .pole_n(pole_n), .sr_clk(sr_clk), .sr_data(sr_data),
    .sw_map(sw_map), .rot_idx(rot_idx), .scan_valid(scan_valid)
  );

  swscan_top #(.NUM_POS(N), .CLK_HI(HI), .CLK_LO(LO), .SETTLE_CYC(SET2)) i_swscan_top_settle (
    .clk(clk), .rst(rst), .start(start2), .free_run(1'b0),
    .rot_mask(8'hFF), .pole_n(1'b1), .sr_clk(sr_clk2), .sr_data(sr_data2),
    .sw_map(map2), .rot_idx(rot2), .scan_valid(valid2)
  );

  // External shift register model.
  always @(posedge sr_clk) begin
    if (sr_data) begin
      ones = ones + 1;
      if (rises != 0) late_one = 1;
    end
    rises = rises + 1;
    srq = {srq[6:0], sr_data};
  end

  // Measure the high time of the shift clock.
  always @(negedge clk) begin
    if (sr_clk) hi_run = hi_run + 1;
    else if (hi_run != 0) begin
      if (hi_run != HI) hi_bad = 1;
      hi_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    cmp++;
    if (!ok) begin
      mism++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_rot(input logic [7:0] v);
    logic [7:0] j = v;
    int idx = 0;
    for (int g = 0; g < 8 && !j[0]; g++) begin
      j[7] = 1'b1;
      j = j >> 1;
      idx++;
    end
    return idx;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!scan_valid && n < 2000) begin
      tick();
      n++;
    end
  endtask

  task automatic run_pass(input logic [7:0] c, input logic [7:0] m, output int n);
    closed = c;
    mask = m;
    rises = 0; ones = 0; late_one = 0; hi_bad = 0;
    @(negedge clk) start = 1'b1;
    tick();
    start = 1'b0;
    wait_valid(n);
  endtask

  int n, m, cnt;

  initial begin
    repeat (4) tick();
    // R1: state held in reset
    check(!sr_clk && !sr_data && !scan_valid, "R1 reset outputs", {sr_clk, sr_data, scan_valid}, 0);
    check(sw_map == 0 && rot_idx == 0, "R1 reset map/index", sw_map, 0);
    @(negedge clk) rst = 1'b0;
    tick();
    check(!sr_clk && !scan_valid && sw_map == 0, "R1 after release", {sr_clk, scan_valid}, 0);

    // R10: no pass begins without start or free_run
    cnt = 0;
    repeat (30) begin tick(); if (sr_clk || scan_valid) cnt++; end
    check(cnt == 0, "R10 idle without request", cnt, 0);

    foreach (VEC[v]) begin
      run_pass(VEC[v][15:8], VEC[v][7:0], n);
      check(n == PASS, "R3 pass length", n, PASS);
      check(rises == N && !hi_bad, "R3 shift clock count/high time", rises, N);
      check(ones == 1 && !late_one, "R2 single leading one", ones, 1);
      check(sw_map == VEC[v][15:8], "R4 R5 switch map", sw_map, VEC[v][15:8]);
      check(int'(rot_idx) == model_rot(VEC[v][15:8] & VEC[v][7:0]),
            (VEC[v][15:8] & VEC[v][7:0]) == 0 ? "R7 empty rotary group" : "R6 rotary index",
            rot_idx, model_rot(VEC[v][15:8] & VEC[v][7:0]));
      tick();
      check(!scan_valid, "R8 valid one cycle", scan_valid, 0);
      repeat (5) tick();
      check(sw_map == VEC[v][15:8], "R8 map holds", sw_map, VEC[v][15:8]);
    end

    // R9: start during a pass is ignored
    closed = 8'h11; mask = 8'hFF;
    @(negedge clk) start = 1'b1;
    tick();
    start = 1'b0;
    n = 0;
    while (!scan_valid && n < 2000) begin
      tick();
      n++;
      start = (n == 10);
    end
    start = 1'b0;
    check(n == PASS, "R9 pass length unchanged", n, PASS);
    cnt = 0;
    repeat (60) begin tick(); if (scan_valid) cnt++; end
    check(cnt == 0, "R9 no extra pass", cnt, 0);

    // R10: continuous passes
    closed = 8'h24; mask = 8'h0C;
    @(negedge clk) free_run = 1'b1;
    wait_valid(n);
    m = 0;
    tick(); m++;
    while (!scan_valid && m < 2000) begin tick(); m++; end
    check(m == PASS + 1, "R10 free-run period", m, PASS + 1);
    check(sw_map == 8'h24 && rot_idx == 2, "R10 free-run result", sw_map, 8'h24);
    free_run = 1'b0;
    cnt = 0;
    repeat (60) begin tick(); if (scan_valid) cnt++; end
    check(cnt == 0, "R10 stops when free_run low", cnt, 0);

    // R11: settling wait lengthens each step
    @(negedge clk) start2 = 1'b1;
    tick();
    start2 = 1'b0;
    n = 0;
    while (!valid2 && n < 2000) begin tick(); n++; end
    check(n == PASS2, "R11 settle pass length", n, PASS2);
    check(map2 == 0 && rot2 == 7, "R11 settle result", map2, 0);

    // R1: reset in the middle of a pass
    closed = 8'h0F; mask = 8'hFF;
    @(negedge clk) start = 1'b1;
    tick();
    start = 1'b0;
    repeat (12) tick();
    rst = 1'b1;
    repeat (2) tick();
    check(!sr_clk && !sr_data && sw_map == 0 && rot_idx == 0, "R1 mid-pass reset", sw_map, 0);
    rst = 1'b0;
    cnt = 0;
    repeat (60) begin tick(); if (scan_valid || sr_clk) cnt++; end
    check(cnt == 0, "R1 abandoned pass", cnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mism);
    $finish;
  end

  initial begin
    #800000;
    mism++;
    cmp++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mism);
    $finish;
  end

endmodule